// File: doc/BRIEF.md
# Page-buffered write commit unit

This unit sits between a serial-bus slave and a byte-wide storage array. While a write transaction is open, it gathers incoming data bytes into a small page buffer. Each byte lands in the slot given by the low bits of a running word pointer, and a per-slot flag records that the slot now holds data. Only the low pointer bits advance, so a long burst wraps around inside one page and never moves into the next one.

When the slave reports the end-of-transaction condition with at least one byte gathered, the unit raises `busy` and runs a fixed-length internal program delay. It then scans the page slots in ascending order and drives the array write port for each flagged slot only. The unit clears its flags and drops `busy` when the scan ends. A high protect level at the end-of-transaction throws the gathered data away, and no program cycle starts. A new transaction start or an abort strobe that arrives before the end condition also throws the gathered data away. The pointer is exported so the slave can use it as the shared current-address counter.

Top module: `pgwr_commit`

## Requirements
- R1: After reset, `busy` and `arr_we` are 0 and `next_addr` is 0.
- R2: A `txn_begin` pulse loads `next_addr` from `txn_addr`. Each accepted `byte_vld` stores `byte_data` in slot `next_addr[2:0]` and then adds one to `next_addr[2:0]` only. Bits [7:3] do not change.
- R3: A burst of more than 8 bytes wraps to slot 0 of the same page. A later byte sent to a slot replaces the earlier value held in that slot.
- R4: A `stop_stb` with at least one byte gathered and `wp` low sets `busy` to 1 on the next cycle. `busy` then stays high for exactly WAIT_CYC + 8 cycles.
- R5: During the last 8 busy cycles, the unit writes every flagged slot s and no unflagged slot. Each write goes to address {`next_addr[7:3]`, s}, and the slots are written in ascending order. `arr_we` is never 1 while `busy` is 0.
- R6: When a commit completes, all slot flags are clear, so a following `stop_stb` with no new bytes starts no program cycle.
- R7: An `abort_stb` or `txn_begin` before `stop_stb` discards the gathered bytes. A following `stop_stb` then starts no program cycle, and nothing is written.
- R8: If `wp` is 1 when `stop_stb` arrives, `busy` stays 0 and nothing is written. The gathered bytes are discarded.
- R9: While `busy` is 1, the unit ignores `txn_begin`, `byte_vld`, `abort_stb` and `stop_stb`. `next_addr` holds its value, and no extra byte is committed.
- R10: After a commit, `next_addr` is one past the last byte written, wrapped within the page.
- R11: A `stop_stb` with no byte gathered starts no program cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| txn_begin | input | 1 | Write transaction start; loads the pointer and discards gathered bytes |
| txn_addr | input | 8 | Starting word address for the transaction |
| byte_vld | input | 1 | One data byte is present on `byte_data` |
| byte_data | input | 8 | Data byte |
| stop_stb | input | 1 | End-of-transaction strobe |
| abort_stb | input | 1 | Discard the gathered bytes |
| wp | input | 1 | Write protect level; 1 blocks the commit |
| arr_we | output | 1 | Array write enable |
| arr_addr | output | 8 | Array write address |
| arr_wdata | output | 8 | Array write data |
| busy | output | 1 | Program cycle in progress |
| next_addr | output | 8 | Current word pointer |

## Verification
The hardest condition to create from the ports is traffic that arrives while the program cycle runs. A slave behaving correctly would never send such traffic, yet the unit must ignore all of it. The bench deliberately sends bytes, a new start address, an abort and an extra end strobe in the middle of the busy window. It then checks that the pointer held its value and that the committed page matches the bytes gathered before the end strobe. Random bursts of up to 12 bytes provide wraps and overwritten slots, and random protect and abort choices cover the discard paths.

// File: rtl/pgwr_pkg.sv
// Shared types for the page write commit unit.
package pgwr_pkg;
    // Phase of the commit sequencer.
    typedef enum logic [1:0] {
        PH_FILL = 2'd0,   // gathering bytes
        PH_WAIT = 2'd1,   // program delay
        PH_PROG = 2'd2    // scanning slots into the array
    } phase_t;
endpackage

// File: rtl/pgwr_slots.sv
// Page slot storage: one data register and one written-flag per slot.
// Assumes at most one write per cycle; clr has priority over wr_en.
module pgwr_slots #(
    parameter int PAGE_BYTES = 8,
    parameter int DATA_W     = 8,
    parameter int IDX_W      = 3
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  clr,
    input  logic                                  wr_en,
    input  logic [IDX_W-1:0]                      wr_idx,
    input  logic [DATA_W-1:0]                     wr_data,
    output logic [PAGE_BYTES-1:0][DATA_W-1:0]     slot_data,
    output logic [PAGE_BYTES-1:0]                 slot_vld
);
    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        // Hold one byte and its written flag.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_data[g] <= '0;
                slot_vld[g]  <= 1'b0;
            end else if (clr) begin
                slot_vld[g]  <= 1'b0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                slot_data[g] <= wr_data;
                slot_vld[g]  <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/pgwr_seq.sv
// Commit sequencer: program delay of WAIT_CYC cycles, then one slot per
// cycle in ascending order. Assumes WAIT_CYC >= 1.
module pgwr_seq
    import pgwr_pkg::*;
#(
    parameter int PAGE_BYTES = 8,
    parameter int WAIT_CYC   = 250000,
    parameter int IDX_W      = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stop_stb,
    input  logic             wp,
    input  logic             any_vld,
    output logic             busy,
    output logic             prog,
    output logic             done,
    output logic [IDX_W-1:0] scan_idx
);
    localparam int CNT_W = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(WAIT_CYC - 1);
    localparam logic [IDX_W-1:0] SLOT_LAST = IDX_W'(PAGE_BYTES - 1);

    phase_t           phase;
    logic [CNT_W-1:0] cnt;

    // Advance the phase, the delay counter and the slot scan.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_FILL;
            cnt      <= '0;
            scan_idx <= '0;
        end else begin
            case (phase)
                PH_FILL: if (stop_stb && any_vld && !wp) begin
                    phase <= PH_WAIT;
                    cnt   <= '0;
                end
                PH_WAIT: if (cnt == CNT_LAST) begin
                    phase    <= PH_PROG;
                    scan_idx <= '0;
                end else begin
                    cnt <= cnt + CNT_W'(1);
                end
                PH_PROG: if (scan_idx == SLOT_LAST) begin
                    phase <= PH_FILL;
                end else begin
                    scan_idx <= scan_idx + IDX_W'(1);
                end
                default: phase <= PH_FILL;
            endcase
        end
    end

    // Decode phase outputs.
    always_comb begin
        busy = (phase != PH_FILL);
        prog = (phase == PH_PROG);
        done = prog && (scan_idx == SLOT_LAST);
    end
endmodule

// File: rtl/pgwr_commit.sv
// Page-buffered write commit unit. Gathers bytes of one write transaction
// in a page buffer, then after the end strobe runs a timed program cycle
// and writes only the flagged slots to the array. Assumes the slave never
// asserts byte_vld in the same cycle as stop_stb.
module pgwr_commit #(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 8,
    parameter int WAIT_CYC   = 250000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              txn_begin,
    input  logic [ADDR_W-1:0] txn_addr,
    input  logic              byte_vld,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              stop_stb,
    input  logic              abort_stb,
    input  logic              wp,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_wdata,
    output logic              busy,
    output logic [ADDR_W-1:0] next_addr
);
    localparam int IDX_W = $clog2(PAGE_BYTES);

    logic [ADDR_W-1:0]                ptr;
    logic [PAGE_BYTES-1:0][DATA_W-1:0] slot_data;
    logic [PAGE_BYTES-1:0]            slot_vld;
    logic                             any_vld;
    logic                             prog;
    logic                             done;
    logic [IDX_W-1:0]                 scan_idx;
    logic                             take_byte;
    logic                             drop_all;

    // Decide which inputs are accepted while gathering.
    always_comb begin
        take_byte = !busy && byte_vld && !txn_begin && !abort_stb;
        drop_all  = done || (!busy && (txn_begin || abort_stb || (stop_stb && wp)));
        any_vld   = |slot_vld;
    end

    // Word pointer: load on start, wrap-increment low bits per byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (!busy && txn_begin) begin
            ptr <= txn_addr;
        end else if (take_byte) begin
            ptr[IDX_W-1:0] <= ptr[IDX_W-1:0] + IDX_W'(1);
        end
    end

    pgwr_slots #(
        .PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W), .IDX_W(IDX_W)
    ) u_slots (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (drop_all),
        .wr_en    (take_byte),
        .wr_idx   (ptr[IDX_W-1:0]),
        .wr_data  (byte_data),
        .slot_data(slot_data),
        .slot_vld (slot_vld)
    );

    pgwr_seq #(
        .PAGE_BYTES(PAGE_BYTES), .WAIT_CYC(WAIT_CYC), .IDX_W(IDX_W)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .stop_stb(stop_stb),
        .wp      (wp),
        .any_vld (any_vld),
        .busy    (busy),
        .prog    (prog),
        .done    (done),
        .scan_idx(scan_idx)
    );

    // Array write port driven from the current scan slot.
    always_comb begin
        arr_we    = prog && slot_vld[scan_idx];
        arr_addr  = {ptr[ADDR_W-1:IDX_W], scan_idx};
        arr_wdata = slot_data[scan_idx];
        next_addr = ptr;
    end
endmodule

// File: rtl/pgwr_commit_chk.sv
// Protocol checker for pgwr_commit, attached by bind below.
module pgwr_commit_chk #(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stop_stb,
    input logic              wp,
    input logic              busy,
    input logic              arr_we,
    input logic [ADDR_W-1:0] arr_addr,
    input logic [ADDR_W-1:0] next_addr,
    input logic              any_vld
);
    p_we_in_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy);

    p_page_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> (arr_addr[ADDR_W-1:IDX_W] == next_addr[ADDR_W-1:IDX_W]));

    p_ascending_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && $past(arr_we) && $past(busy))
            |-> (arr_addr[IDX_W-1:0] > $past(arr_addr[IDX_W-1:0])));

    p_stop_starts_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && stop_stb && !wp && any_vld) |=> busy);

    p_wp_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && stop_stb && wp) |=> !busy);

    p_addr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(next_addr));

    p_flags_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !any_vld);
endmodule

bind pgwr_commit pgwr_commit_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .stop_stb (stop_stb),
    .wp       (wp),
    .busy     (busy),
    .arr_we   (arr_we),
    .arr_addr (arr_addr),
    .next_addr(next_addr),
    .any_vld  (any_vld)
);

// File: tb/sim_pgwr_commit.sv
`timescale 1ns/1ps
module sim_pgwr_commit;
    localparam int TB_WAIT = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       txn_begin = 1'b0;
    logic [7:0] txn_addr = '0;
    logic       byte_vld = 1'b0;
    logic [7:0] byte_data = '0;
    logic       stop_stb = 1'b0;
    logic       abort_stb = 1'b0;
    logic       wp = 1'b0;
    logic       arr_we;
    logic [7:0] arr_addr;
    logic [7:0] arr_wdata;
    logic       busy;
    logic [7:0] next_addr;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int run = 0;
    int last_run = 0;
    int nwrites = 0;
    int last_slot = -1;
    logic [7:0] mem_img [0:255];
    logic [7:0] exp_mem [0:255];

    always #10 clk = ~clk;

    pgwr_commit #(.WAIT_CYC(TB_WAIT)) u0 (
        .clk(clk), .rst_n(rst_n), .txn_begin(txn_begin), .txn_addr(txn_addr),
        .byte_vld(byte_vld), .byte_data(byte_data), .stop_stb(stop_stb),
        .abort_stb(abort_stb), .wp(wp), .arr_we(arr_we), .arr_addr(arr_addr),
        .arr_wdata(arr_wdata), .busy(busy), .next_addr(next_addr)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] wrap_next(input logic [7:0] a);
        return {a[7:3], a[2:0] + 3'd1};
    endfunction

    // Monitor: busy run length, array image, write order.
    always @(negedge clk) begin
        if (busy) run++;
        else if (run != 0) begin last_run = run; run = 0; end
        if (!busy) last_slot = -1;
        if (arr_we) begin
            if (!busy) chk(1'b0, "R5", "write outside busy", 1, 0);
            if (int'(arr_addr[2:0]) <= last_slot)
                chk(1'b0, "R5", "slot order", int'(arr_addr[2:0]), last_slot + 1);
            last_slot = int'(arr_addr[2:0]);
            mem_img[arr_addr] = arr_wdata;
            nwrites++;
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic p_begin(input logic [7:0] a);
        txn_begin = 1'b1; txn_addr = a;
        @(negedge clk); txn_begin = 1'b0;
    endtask
    task automatic p_byte(input logic [7:0] d);
        byte_vld = 1'b1; byte_data = d;
        @(negedge clk); byte_vld = 1'b0;
    endtask
    task automatic p_abort();
        abort_stb = 1'b1;
        @(negedge clk); abort_stb = 1'b0;
    endtask
    task automatic p_stop();
        stop_stb = 1'b1;
        @(negedge clk); stop_stb = 1'b0;
    endtask

    // One transaction. mode: 0 normal, 1 abort before stop, 2 restart before stop.
    task automatic do_txn(input logic [7:0] a, input int n, input bit wpv,
                          input int mode, input bit poke);
        logic [7:0] mptr = a;
        logic [7:0] mbuf [0:7];
        bit         mflg [0:7];
        int         nflag = 0;
        int         w0;
        bit         exp_busy;
        bit         ok;
        logic [7:0] hold;
        for (int i = 0; i < 8; i++) begin mflg[i] = 1'b0; mbuf[i] = '0; end
        wp = wpv;
        p_begin(a);
        for (int i = 0; i < n; i++) begin
            logic [7:0] d = 8'($urandom);
            mbuf[mptr[2:0]] = d;
            mflg[mptr[2:0]] = 1'b1;
            mptr = wrap_next(mptr);
            p_byte(d);
        end
        chk(next_addr == mptr, "R2", "pointer after bytes", next_addr, mptr);
        if (mode == 1) begin
            p_abort();
            for (int i = 0; i < 8; i++) mflg[i] = 1'b0;
        end else if (mode == 2) begin
            p_begin(a);
            mptr = a;
            for (int i = 0; i < 8; i++) mflg[i] = 1'b0;
        end
        for (int i = 0; i < 8; i++) if (mflg[i]) nflag++;
        exp_busy = (nflag != 0) && !wpv;
        w0 = nwrites;
        p_stop();
        chk(busy == exp_busy, wpv ? "R8" : (mode != 0 ? "R7" : (n == 0 ? "R11" : "R4")),
            "busy after stop", busy, exp_busy);
        if (exp_busy) begin
            if (poke) begin
                hold = next_addr;
                txn_begin = 1'b1; txn_addr = ~a; byte_vld = 1'b1; byte_data = 8'h5A;
                abort_stb = 1'b1; stop_stb = 1'b1;
                repeat (5) @(negedge clk);
                txn_begin = 1'b0; byte_vld = 1'b0; abort_stb = 1'b0; stop_stb = 1'b0;
                chk(next_addr == hold, "R9", "pointer held while busy", next_addr, hold);
            end
            while (busy) @(negedge clk);
            @(negedge clk);
            chk(last_run == TB_WAIT + 8, "R4", "busy length", last_run, TB_WAIT + 8);
            chk(nwrites - w0 == nflag, poke ? "R9" : "R5", "write count",
                nwrites - w0, nflag);
            for (int i = 0; i < 8; i++)
                if (mflg[i]) exp_mem[{a[7:3], 3'(i)}] = mbuf[i];
            ok = 1'b1;
            for (int i = 0; i < 8; i++)
                if (mem_img[{a[7:3], 3'(i)}] !== exp_mem[{a[7:3], 3'(i)}]) ok = 1'b0;
            chk(ok, n > 8 ? "R3" : "R5", "page contents", ok, 1);
            chk(next_addr == mptr, "R10", "pointer after commit", next_addr, mptr);
        end else begin
            repeat (3) @(negedge clk);
            chk(nwrites == w0, wpv ? "R8" : "R7", "no writes", nwrites - w0, 0);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) begin mem_img[i] = '0; exp_mem[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0 && arr_we == 1'b0, "R1", "busy/we at reset", {busy, arr_we}, 0);
        chk(next_addr == 8'h00, "R1", "pointer at reset", next_addr, 0);

        do_txn(8'h13, 1, 1'b0, 0, 1'b0);          // single byte
        do_txn(8'h2E, 10, 1'b0, 0, 1'b0);         // R3 wrap and overwrite
        do_txn(8'hF8, 8, 1'b0, 0, 1'b0);          // full page
        p_stop();                                  // R6 no bytes since commit
        chk(busy == 1'b0, "R6", "stop after commit", busy, 0);
        do_txn(8'h40, 0, 1'b0, 0, 1'b0);          // R11 empty transaction
        do_txn(8'h51, 3, 1'b0, 1, 1'b0);          // R7 abort
        do_txn(8'h62, 4, 1'b0, 2, 1'b0);          // R7 restart
        do_txn(8'h73, 5, 1'b1, 0, 1'b0);          // R8 protected
        wp = 1'b0;
        p_stop();                                  // R8 buffer was dropped
        chk(busy == 1'b0, "R8", "stop after protected drop", busy, 0);
        do_txn(8'h85, 6, 1'b0, 0, 1'b1);          // R9 traffic while busy

        for (int t = 0; t < 60; t++) begin
            logic [7:0] a = 8'($urandom);
            int n = 1 + int'($urandom % 12);
            bit w = ($urandom % 4) == 0;
            int m = (($urandom % 6) == 0) ? 1 + int'($urandom % 2) : 0;
            do_txn(a, n, w, m, ($urandom % 5) == 0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule